// File: doc/BRIEF.md
# Serial Volume and Output-Mode Control Register

This block takes an 8-bit control word from a three-wire serial port and stores it in a holding register. The port has a data line, a serial clock and an active-high enable. A faster system clock samples all three lines through two-flop synchronizers. Edges are detected in the system clock domain, so the serial clock needs no clock tree of its own. The system clock must run at least four times faster than the serial clock.

A frame opens when the enable rises. Data bits are taken on rising serial-clock edges, least significant bit first. When the enable falls, the word is committed, but only if eight bits have arrived. The stored word is split into a 3-bit output-mode field and a 5-bit gain code. Two gain paths decode the code into signed gains in 0.1 dB units. A one-cycle update strobe marks every commit.

The framer is a three-state machine. `ST_IDLE` waits for an enable rise (transition IDLE→SHIFT, which clears the bit count). `ST_SHIFT` shifts one bit per serial-clock rise. It moves SHIFT→FULL on the eighth bit, or SHIFT→IDLE (abort, nothing committed) if the enable falls first. `ST_FULL` ignores all further clock and data activity. It moves FULL→IDLE on the enable fall and commits the word.

Top module: `serctl_reg`

## Requirements
- R1: After reset: mode is 0, gain code is 0, line gain is -345, phone gain is -405, and the update strobe is low.
- R2: Data is sampled on rising serial-clock edges. The first bit received lands in word bit 0 (LSB first).
- R3: A complete frame is committed on the falling edge of the enable. `update_o` is high for exactly one system cycle, in the same cycle the new outputs first appear.
- R4: If the enable falls before eight rising serial-clock edges, the holding register is left unchanged and no update strobe occurs.
- R5: Rising serial-clock edges after the eighth one in a frame have no effect. Only the first eight bits are stored.
- R6: Word bits [2:0] drive `mode_o` (0 to 7). Word bits [7:3] drive `gain_code_o`, with word bit 3 as the code's LSB.
- R7: `line_gain_o` is the signed value -345 + 15·n, in 0.1 dB units, where n is the gain code.
- R8: `phone_gain_o` is the signed value -405 + 15·n, in 0.1 dB units. It is always exactly 60 below the line gain.
- R9: Every enable rise starts a new frame with the bit count cleared. Bits from an aborted frame never carry into the next committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_en | input | 1 | Active-high frame enable; falling edge commits |
| mode_o | output | 3 | Committed output-mode field |
| gain_code_o | output | 5 | Committed gain code |
| line_gain_o | output | 10 | Line-path gain, signed, 0.1 dB units |
| phone_gain_o | output | 10 | Phone-path gain, signed, 0.1 dB units |
| update_o | output | 1 | One-cycle pulse on each commit |

## Verification
The assertions assume each serial-clock level and each enable level lasts several system cycles. They also assume data is steady around each serial-clock rise and that the enable does not change in the same cycle as a serial-clock rise. Under these conditions, the synchronized copies keep the sender's ordering.

The stimulus keeps serial-clock half periods at 60 ns against a 4 ns system clock. Data changes half a serial period before each rise. Each enable edge is separated from clock edges by at least one half period.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } frame_st_t;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Chain of synchronizer flops, one per stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[s] <= '0;
            end else if (s == 0) begin
                stg[s] <= d_i;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/serctl_frame.sv
module serctl_frame
    import serctl_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdat_i,
    input  logic              sen_i,
    output logic [WORD_W-1:0] word_o,
    output logic              commit_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    frame_st_t         state, nxt;
    logic              sclk_d, sen_d;
    logic              clk_rise, en_rise, en_fall;
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    // Edge detection in the system clock domain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sen_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_i;
            sen_d  <= sen_i;
        end
    end

    assign clk_rise = sclk_i & ~sclk_d;
    assign en_rise  = sen_i & ~sen_d;
    assign en_fall  = ~sen_i & sen_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (en_rise) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (en_fall)                           nxt = ST_IDLE;
                else if (clk_rise && cnt == LAST_BIT)  nxt = ST_FULL;
            end
            ST_FULL:  if (en_fall) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Datapath and registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            cnt      <= '0;
            word_o   <= '0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (en_rise) cnt <= '0;
                end
                ST_SHIFT: begin
                    if (!en_fall && clk_rise) begin
                        sh  <= {sdat_i, sh[WORD_W-1:1]};
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_FULL: begin
                    if (en_fall) begin
                        word_o   <= sh;
                        commit_o <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: the shift register moves only on a serial-clock rise inside a frame.
    a_r2_shift_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sh != $past(sh)) |-> ($past(state) == ST_SHIFT && $past(clk_rise)));

    // R5: once full, the captured bits stay put until the commit.
    a_r5_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |=> $stable(sh));

    // R4: a commit only follows a full frame.
    a_r4_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(state) == ST_FULL));
endmodule

// File: rtl/serctl_gain_path.sv
module serctl_gain_path #(
    parameter int CODE_W = 5,
    parameter int OUT_W  = 10,
    parameter int BASE   = -345,
    parameter int STEP   = 15
) (
    input  logic [CODE_W-1:0]        code_i,
    output logic signed [OUT_W-1:0]  gain_o
);
    localparam logic signed [OUT_W-1:0] BASE_V = OUT_W'(BASE);
    localparam logic signed [OUT_W-1:0] STEP_V = OUT_W'(STEP);

    logic signed [OUT_W-1:0] code_ext;
    assign code_ext = $signed({{(OUT_W-CODE_W){1'b0}}, code_i});
    assign gain_o   = BASE_V + STEP_V * code_ext;
endmodule

// File: rtl/serctl_reg.sv
module serctl_reg #(
    parameter int MODE_W     = 3,
    parameter int CODE_W     = 5,
    parameter int GAIN_W     = 10,
    parameter int SYNC_STG   = 2,
    parameter int LINE_BASE  = -345,
    parameter int PHONE_BASE = -405,
    parameter int GAIN_STEP  = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_dat,
    input  logic                     ser_clk,
    input  logic                     ser_en,
    output logic [MODE_W-1:0]        mode_o,
    output logic [CODE_W-1:0]        gain_code_o,
    output logic signed [GAIN_W-1:0] line_gain_o,
    output logic signed [GAIN_W-1:0] phone_gain_o,
    output logic                     update_o
);
    localparam int WORD_W = MODE_W + CODE_W;
    localparam int NPATH  = 2;

    logic [2:0]        syn;
    logic [WORD_W-1:0] word;
    logic              commit;

    serctl_sync #(.W(3), .STAGES(SYNC_STG)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ser_en, ser_clk, ser_dat}),
        .q_o   (syn)
    );

    serctl_frame #(.WORD_W(WORD_W)) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (syn[1]),
        .sdat_i   (syn[0]),
        .sen_i    (syn[2]),
        .word_o   (word),
        .commit_o (commit)
    );

    // Holding register and update strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o      <= '0;
            gain_code_o <= '0;
            update_o    <= 1'b0;
        end else begin
            update_o <= commit;
            if (commit) begin
                mode_o      <= word[MODE_W-1:0];
                gain_code_o <= word[WORD_W-1:MODE_W];
            end
        end
    end

    logic signed [GAIN_W-1:0] gains [NPATH];

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        serctl_gain_path #(
            .CODE_W (CODE_W),
            .OUT_W  (GAIN_W),
            .BASE   ((p == 0) ? LINE_BASE : PHONE_BASE),
            .STEP   (GAIN_STEP)
        ) path_i (
            .code_i (gain_code_o),
            .gain_o (gains[p])
        );
    end

    assign line_gain_o  = gains[0];
    assign phone_gain_o = gains[1];

    // R3: the update strobe lasts a single cycle.
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // R4: the stored fields change only together with an update strobe.
    a_r4_hold_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o) || gain_code_o != $past(gain_code_o)) |-> update_o);

    // R8: the two gain paths keep a fixed 6.0 dB offset.
    a_r8_path_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(line_gain_o) - int'(phone_gain_o)) == (LINE_BASE - PHONE_BASE));
endmodule

// File: tb/serctl_reg_tb_top.sv
module serctl_reg_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_en = 1'b0;
    logic [2:0] mode_o;
    logic [4:0] gain_code_o;
    logic signed [9:0] line_gain_o;
    logic signed [9:0] phone_gain_o;
    logic update_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    serctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .ser_en(ser_en), .mode_o(mode_o), .gain_code_o(gain_code_o),
        .line_gain_o(line_gain_o), .phone_gain_o(phone_gain_o), .update_o(update_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: sends nbits; bits past 8 come from extra. Pushes expected word if full.
    task automatic send(input logic [7:0] b, input int nbits, input logic extra);
        ser_en = 1'b1;
        #60;
        for (int i = 0; i < nbits; i++) begin
            ser_dat = (i < 8) ? b[i] : extra;
            #60 ser_clk = 1'b1;
            #60 ser_clk = 1'b0;
        end
        if (nbits >= 8) exp_q.push_back(b);
        #60 ser_en = 1'b0;
        #120;
    endtask

    // Monitor: compares outputs at each update strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && update_o) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected update", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk("R6 mode",      int'(mode_o),       int'(e[2:0]));
                chk("R2 R6 code",   int'(gain_code_o),  int'(e[7:3]));
                chk("R7 line gain", int'(line_gain_o),  -345 + 15*int'(e[7:3]));
                chk("R8 phone gain",int'(phone_gain_o), -405 + 15*int'(e[7:3]));
            end
        end
    end

    // R3: strobe width measured at the ports.
    int upd_run = 0;
    always @(negedge clk) begin
        if (update_o) upd_run++;
        else begin
            if (upd_run > 1) chk("R3 strobe width", upd_run, 1);
            upd_run = 0;
        end
    end

    bit done = 0;
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #21;
        // R1 reset state
        chk("R1 mode", int'(mode_o), 0);
        chk("R1 code", int'(gain_code_o), 0);
        chk("R1 line", int'(line_gain_o), -345);
        chk("R1 phone", int'(phone_gain_o), -405);
        chk("R1 update", int'(update_o), 0);
        rst_n = 1'b1;
        #40;
        send(8'hA5, 8, 1'b0);
        send(8'h3C, 8, 1'b0);
        send(8'hFF, 8, 1'b0);
        send(8'h01, 8, 1'b0);   // R2 LSB-first
        // R4 short frame: holding register must stay at 0x01
        send(8'hFE, 5, 1'b0);
        #40;
        chk("R4 mode kept", int'(mode_o), 1);
        chk("R4 code kept", int'(gain_code_o), 0);
        // R5 extra bits ignored: 12 clocks, extra ones
        send(8'h5A, 12, 1'b1);
        send(8'h80, 11, 1'b1);
        // R9 aborted frame then a full one
        send(8'hFF, 3, 1'b0);
        send(8'h12, 8, 1'b0);
        // R7 R8 all gain codes, mode sweep
        for (int n = 0; n < 32; n++) send({n[4:0], n[2:0]}, 8, 1'b0);
        #200;
        chk("R3 queue drained", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule